// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint Buffer

This block is the device-to-host staging store for a single USB endpoint. Firmware pushes one byte per write into a loading slot. When the packet is complete, firmware sets a ready bit to hand the packet to the bus side. The serial engine reads the oldest handed-over packet byte by byte and then reports it as delivered. The store has two slots that are used in ping-pong fashion. With double buffering on, firmware can fill the second slot while the first one waits to be sent.

The ready bit as seen by firmware reflects whether a slot is still free for loading. In double-buffer mode it drops back right after the first hand-over and stays high only once both slots are taken. A packet-present flag tells firmware whether anything at all is buffered. Optional automatic hand-over fires on the write that reaches a programmed maximum packet size. A flush command and the bus-side outcomes (delivered, stall) produce a one-cycle event pulse for the interrupt logic.

Top module: `inEpBuffer`

## Requirements
- R1: After reset `pktRdy`, `pktPresent`, `busAvail` and `inEvent` are 0.
- R2: Each accepted `cpuWrEn` appends `cpuWrData` to the loading packet. The bus side returns the bytes in write order on `busRdData`, and each `busRdEn` advances to the next byte.
- R3: With `dblBufEn`=0, a hand-over via `cpuSetRdy` sets `pktRdy` and `busAvail` from the next cycle. `pktRdy` stays 1 until `busSent` retires the packet.
- R4: With `dblBufEn`=1, the first hand-over leaves `pktRdy` at 0. A second hand-over while the first packet is still queued sets `pktRdy` to 1.
- R5: A hand-over with no bytes loaded queues a packet with `busLen` 0.
- R6: `pktPresent` is 0 exactly when no packet is queued and no byte is loaded.
- R7: With `autoSetEn`=1 and `maxPkt`≠0, the write that brings the loaded count to `maxPkt` hands the packet over with no `cpuSetRdy`. With `maxPkt`=0, no automatic hand-over happens.
- R8: `flushReq` discards the oldest queued packet, or the partly loaded bytes when nothing is queued.
- R9: `busSent`, `busStall` and `flushReq` each give a one-cycle `inEvent` in the following cycle. A hand-over alone gives no event.
- R10: Queued packets reach the bus side in the order they were handed over, each with its own `busLen`.
- R11: Writes beyond `SLOT_BYTES` in one packet are ignored. Writes while no slot is free for loading are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dblBufEn | input | 1 | Use both slots (change only while empty) |
| autoSetEn | input | 1 | Enable automatic hand-over at max size |
| maxPkt | input | MAXP_W | Maximum packet size in bytes; 0 disables automatic hand-over |
| cpuWrEn | input | 1 | Firmware byte write strobe |
| cpuWrData | input | DATA_W | Firmware write byte |
| cpuSetRdy | input | 1 | Firmware writes 1 to the ready bit |
| flushReq | input | 1 | Flush command |
| pktRdy | output | 1 | Ready bit readback |
| pktPresent | output | 1 | Any data buffered |
| busAvail | output | 1 | A queued packet is available to the bus side |
| busLen | output | CNT_W | Byte count of the oldest queued packet |
| busRdEn | input | 1 | Bus side consumes the current byte |
| busRdData | output | DATA_W | Current byte of the oldest queued packet |
| busSent | input | 1 | Oldest packet delivered; retire it |
| busStall | input | 1 | Stall handshake was sent |
| inEvent | output | 1 | One-cycle endpoint event pulse |

## Verification
A corrupted slot index or queue count shows up at the first drain. The bench then sees the wrong `busLen` or a byte out of order on `busRdData` in the cycle after the hand-over. A bad fill counter either truncates or extends a packet, or it fires the automatic hand-over on the wrong write, which shows as a wrong `busAvail` one cycle later. Wrong free-slot accounting makes `pktRdy` read back incorrectly in the cycle after `cpuSetRdy`. The bench compares every byte, length and flag against a queue model held in the bench.

// File: rtl/inEpPkg.sv
package inEpPkg;
  typedef struct packed {
    logic wrAccept;    // store cpu byte into loading slot
    logic commit;      // hand loading slot over to bus side
    logic retire;      // drop oldest queued packet
    logic dropPartial; // discard loaded bytes
    logic advRd;       // bus side consumes a byte
    logic wrSlot;      // slot being loaded
    logic rdSlot;      // oldest queued slot
  } epStrobe_t;
endpackage

// File: rtl/inEpCtl.sv
module inEpCtl
  import inEpPkg::*;
#(
  parameter int SLOT_BYTES = 64,
  parameter int MAXP_W     = 8,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblBufEn,
  input  logic              autoSetEn,
  input  logic [MAXP_W-1:0] maxPkt,
  input  logic              cpuWrEn,
  input  logic              cpuSetRdy,
  input  logic              flushReq,
  input  logic              busRdEn,
  input  logic              busSent,
  input  logic              busStall,
  input  logic [CNT_W-1:0]  fillCnt,
  output epStrobe_t         stb,
  output logic              pktRdy,
  output logic              pktPresent,
  output logic              busAvail,
  output logic              inEvent
);
  localparam int CW = (CNT_W > MAXP_W) ? CNT_W : MAXP_W;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SLOT_BYTES);

  logic [1:0] commitCnt;
  logic       rdSlot;
  logic [1:0] cap;
  logic       loadOpen;
  logic       wrAccept;
  logic       dropPartial;
  logic       autoHit;
  logic       commit;
  logic       retire;
  logic [CNT_W-1:0] nextFill;

  assign cap         = dblBufEn ? 2'd2 : 2'd1;
  assign loadOpen    = commitCnt < cap;
  assign dropPartial = flushReq && (commitCnt == 2'd0);
  assign wrAccept    = cpuWrEn && loadOpen && !dropPartial && (fillCnt < FULL_CNT);
  assign nextFill    = fillCnt + CNT_W'(wrAccept);
  assign autoHit     = autoSetEn && (maxPkt != '0) && wrAccept &&
                       (CW'(nextFill) == CW'(maxPkt));
  assign commit      = loadOpen && !dropPartial && (cpuSetRdy || autoHit);
  assign retire      = (commitCnt != 2'd0) && (busSent || flushReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitCnt <= 2'd0;
      rdSlot    <= 1'b0;
      inEvent   <= 1'b0;
    end else begin
      commitCnt <= commitCnt + 2'(commit) - 2'(retire);
      if (retire) rdSlot <= ~rdSlot;
      inEvent <= busSent || busStall || flushReq;
    end
  end

  always_comb begin
    stb.wrAccept    = wrAccept;
    stb.commit      = commit;
    stb.retire      = retire;
    stb.dropPartial = dropPartial;
    stb.advRd       = busRdEn && (commitCnt != 2'd0);
    stb.wrSlot      = rdSlot ^ commitCnt[0];
    stb.rdSlot      = rdSlot;
  end

  assign pktRdy     = commitCnt >= cap;
  assign busAvail   = commitCnt != 2'd0;
  assign pktPresent = busAvail || (fillCnt != '0);
endmodule

// File: rtl/inEpData.sv
module inEpData
  import inEpPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 64,
  parameter int CNT_W      = 7,
  parameter int PTR_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  epStrobe_t         stb,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [CNT_W-1:0]  fillCnt,
  output logic [CNT_W-1:0]  busLen,
  output logic [DATA_W-1:0] busRdData
);
  logic [CNT_W-1:0]  slotLen [2];
  logic [DATA_W-1:0] slotRd  [2];
  logic [CNT_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  commitLen;

  assign commitLen = fillCnt + CNT_W'(stb.wrAccept);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillCnt <= '0;
    else if (stb.dropPartial || stb.commit) fillCnt <= '0;
    else if (stb.wrAccept) fillCnt <= commitLen;
  end

  for (genvar s = 0; s < 2; s++) begin : gSlot
    logic [DATA_W-1:0] slotMem [SLOT_BYTES];

    always_ff @(posedge clk) begin
      if (stb.wrAccept && (stb.wrSlot == 1'(s)))
        slotMem[fillCnt[PTR_W-1:0]] <= cpuWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotLen[s] <= '0;
      else if (stb.commit && (stb.wrSlot == 1'(s))) slotLen[s] <= commitLen;
    end

    assign slotRd[s] = slotMem[rdPtr[PTR_W-1:0]];
  end

  assign busLen = slotLen[stb.rdSlot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPtr <= '0;
    else if (stb.retire) rdPtr <= '0;
    else if (stb.advRd && (rdPtr < busLen)) rdPtr <= rdPtr + 1'b1;
  end

  assign busRdData = (rdPtr < busLen) ? slotRd[stb.rdSlot] : '0;
endmodule

// File: rtl/inEpBuffer.sv
module inEpBuffer
  import inEpPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SLOT_BYTES = 64,
  parameter int MAXP_W     = 8,
  localparam int CNT_W     = $clog2(SLOT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblBufEn,
  input  logic              autoSetEn,
  input  logic [MAXP_W-1:0] maxPkt,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuSetRdy,
  input  logic              flushReq,
  output logic              pktRdy,
  output logic              pktPresent,
  output logic              busAvail,
  output logic [CNT_W-1:0]  busLen,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              busSent,
  input  logic              busStall,
  output logic              inEvent
);
  localparam int PTR_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;

  epStrobe_t        stb;
  logic [CNT_W-1:0] fillCnt;

  inEpCtl #(.SLOT_BYTES(SLOT_BYTES), .MAXP_W(MAXP_W), .CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .dblBufEn(dblBufEn), .autoSetEn(autoSetEn),
    .maxPkt(maxPkt), .cpuWrEn(cpuWrEn), .cpuSetRdy(cpuSetRdy),
    .flushReq(flushReq), .busRdEn(busRdEn), .busSent(busSent),
    .busStall(busStall), .fillCnt(fillCnt), .stb(stb), .pktRdy(pktRdy),
    .pktPresent(pktPresent), .busAvail(busAvail), .inEvent(inEvent)
  );

  inEpData #(.DATA_W(DATA_W), .SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W),
             .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWrData(cpuWrData),
    .fillCnt(fillCnt), .busLen(busLen), .busRdData(busRdData)
  );
endmodule

// File: rtl/inEpChk.sv
module inEpChk #(
  parameter int SLOT_BYTES = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             dblBufEn,
  input logic             cpuSetRdy,
  input logic             flushReq,
  input logic             busSent,
  input logic             busStall,
  input logic             pktRdy,
  input logic             pktPresent,
  input logic             busAvail,
  input logic [CNT_W-1:0] busLen,
  input logic             inEvent
);
  AST_RDY_HELD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dblBufEn && busAvail) |-> pktRdy); // R3
  AST_RDY_IMPLIES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    pktRdy |-> pktPresent); // R6
  AST_EMPTY_NO_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    !pktPresent |-> !busAvail); // R6
  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    inEvent |-> $past(busSent || busStall || flushReq)); // R9
  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSetRdy && !busSent && !busStall && !flushReq) |=> !inEvent); // R9
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busAvail |-> (busLen <= CNT_W'(SLOT_BYTES))); // R11
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busAvail && $past(busAvail) && !$past(busSent) && !$past(flushReq))
      |-> $stable(busLen)); // R10
endmodule

bind inEpBuffer inEpChk #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W)) uChk (.*);

// File: tb/inEpBuffer_test.sv
module inEpBuffer_test;
  localparam int SLOT = 64;

  logic clk = 0, rstN = 0;
  logic dblBufEn = 0, autoSetEn = 0, cpuWrEn = 0, cpuSetRdy = 0, flushReq = 0;
  logic busRdEn = 0, busSent = 0, busStall = 0;
  logic [7:0] maxPkt = 0, cpuWrData = 0;
  logic pktRdy, pktPresent, busAvail, inEvent;
  logic [6:0] busLen;
  logic [7:0] busRdData;

  int nChk = 0, nFail = 0;
  byte curQ[$];
  byte dataQ[$];
  int  lenQ[$];
  bit  mDbl = 0, mAuto = 0;
  int  mMax = 0;

  inEpBuffer uut (.*);

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int capOf();
    return mDbl ? 2 : 1;
  endfunction

  task automatic modelCommit();
    lenQ.push_back(curQ.size());
    foreach (curQ[i]) dataQ.push_back(curQ[i]);
    curQ.delete();
  endtask

  task automatic wr(byte d); // R2 R7 R11
    cpuWrEn = 1; cpuWrData = d;
    if (lenQ.size() < capOf() && curQ.size() < SLOT) begin
      curQ.push_back(d);
      if (mAuto && mMax != 0 && curQ.size() == mMax) modelCommit();
    end
    @(negedge clk); cpuWrEn = 0;
  endtask

  task automatic setRdy(); // R3 R4
    cpuSetRdy = 1;
    if (lenQ.size() < capOf()) modelCommit();
    @(negedge clk); cpuSetRdy = 0;
    chk(pktRdy == (lenQ.size() >= capOf()), "R3/R4 pktRdy", pktRdy, lenQ.size() >= capOf());
    chk(inEvent == 0, "R9 no event on hand-over", inEvent, 0);
  endtask

  task automatic checkPresent();
    chk(pktPresent == (lenQ.size() != 0 || curQ.size() != 0), "R6 pktPresent",
        pktPresent, lenQ.size() != 0 || curQ.size() != 0);
    chk(busAvail == (lenQ.size() != 0), "R10 busAvail", busAvail, lenQ.size() != 0);
  endtask

  task automatic drain(); // R2 R5 R10 R9
    int n;
    n = lenQ[0];
    chk(busAvail == 1, "R10 busAvail before drain", busAvail, 1);
    chk(int'(busLen) == n, "R10 busLen", busLen, n);
    for (int i = 0; i < n; i++) begin
      chk(busRdData == 8'(dataQ[i]), "R2 byte order", busRdData, dataQ[i]);
      busRdEn = 1;
      @(negedge clk);
      busRdEn = 0;
    end
    busSent = 1;
    void'(lenQ.pop_front());
    for (int i = 0; i < n; i++) void'(dataQ.pop_front());
    @(negedge clk); busSent = 0;
    chk(inEvent == 1, "R9 event on sent", inEvent, 1);
    checkPresent();
    @(negedge clk);
    chk(inEvent == 0, "R9 event one cycle", inEvent, 0);
  endtask

  task automatic flush(); // R8
    flushReq = 1;
    if (lenQ.size() != 0) begin
      for (int i = 0; i < lenQ[0]; i++) void'(dataQ.pop_front());
      void'(lenQ.pop_front());
    end else curQ.delete();
    @(negedge clk); flushReq = 0;
    chk(inEvent == 1, "R8 flush event", inEvent, 1);
    checkPresent();
  endtask

  initial begin
    #(20 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(pktRdy == 0, "R1 pktRdy", pktRdy, 0);
    chk(pktPresent == 0, "R1 pktPresent", pktPresent, 0);
    chk(busAvail == 0, "R1 busAvail", busAvail, 0);
    chk(inEvent == 0, "R1 inEvent", inEvent, 0);

    // single-buffer: ready held, writes while held ignored (R3, R11)
    for (int i = 0; i < 5; i++) wr(byte'(8'h10 + i));
    checkPresent();
    setRdy();
    wr(8'hEE); wr(8'hEF);
    chk(int'(busLen) == 5, "R11 writes ignored while no free slot", busLen, 5);
    drain();
    chk(pktRdy == 0, "R3 pktRdy after sent", pktRdy, 0);

    // double-buffer ping-pong (R4, R10)
    dblBufEn = 1; mDbl = 1;
    for (int i = 0; i < 3; i++) wr(byte'(8'hA0 + i));
    setRdy();
    for (int i = 0; i < 4; i++) wr(byte'(8'hB0 + i));
    setRdy();
    wr(8'h55);
    drain();
    chk(pktRdy == 0, "R4 slot freed", pktRdy, 0);
    drain();

    // zero-length packet (R5)
    setRdy();
    chk(int'(busLen) == 0, "R5 zero length", busLen, 0);
    drain();

    // overflow truncation (R11)
    for (int i = 0; i < 70; i++) wr(byte'(i));
    setRdy();
    chk(int'(busLen) == SLOT, "R11 slot capacity", busLen, SLOT);
    drain();

    // auto hand-over (R7)
    autoSetEn = 1; mAuto = 1; maxPkt = 5; mMax = 5;
    for (int i = 0; i < 5; i++) wr(byte'(8'hC0 + i));
    chk(busAvail == 1, "R7 auto hand-over", busAvail, 1);
    drain();
    maxPkt = 0; mMax = 0;
    for (int i = 0; i < 5; i++) wr(byte'(i));
    chk(busAvail == 0, "R7 maxPkt zero disables", busAvail, 0);
    flush();
    chk(pktPresent == 0, "R8 partial discarded", pktPresent, 0);
    autoSetEn = 0; mAuto = 0;

    // flush drops oldest queued packet (R8, R10)
    for (int i = 0; i < 2; i++) wr(byte'(8'h70 + i));
    setRdy();
    for (int i = 0; i < 3; i++) wr(byte'(8'h80 + i));
    setRdy();
    flush();
    chk(int'(busLen) == 3, "R8 oldest dropped", busLen, 3);
    drain();

    // stall event (R9)
    busStall = 1;
    @(negedge clk); busStall = 0;
    chk(inEvent == 1, "R9 stall event", inEvent, 1);
    @(negedge clk);
    chk(inEvent == 0, "R9 stall event one cycle", inEvent, 0);

    // constrained random rounds
    for (int r = 0; r < 80; r++) begin
      int len;
      if (r == 40) begin
        autoSetEn = 1; mAuto = 1; maxPkt = 8'($urandom_range(1, 12)); mMax = maxPkt;
      end
      len = ($urandom_range(0, 9) == 0) ? $urandom_range(60, 68) : $urandom_range(0, 14);
      for (int i = 0; i < len; i++) wr(byte'($urandom));
      if ($urandom_range(0, 3) != 0) setRdy();
      checkPresent();
      if (lenQ.size() == 2 || (lenQ.size() != 0 && $urandom_range(0, 1) == 1)) drain();
    end
    while (lenQ.size() != 0) drain();
    if (curQ.size() != 0) flush();
    checkPresent();

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule